// File: doc/BRIEF.md
# Block Hamming Code Generator for Byte Streams

This block watches a byte stream crossing a byte-wide data interface and builds a 3-byte Hamming parity code over fixed-size blocks of that stream. Each code is made of column parities taken over bit positions within the bytes, and line parities taken over byte positions within the block. With these bits, a later correction step can locate and fix any single flipped bit in the block, and it can detect any two flipped bits.

A mode bit chooses one of two block layouts. In short-block mode, two codes are produced over two consecutive 256-byte blocks and placed in result registers one and two. In long-block mode, a single code covers 512 bytes, goes into register one, and leaves register two untouched. Once the last code of the chosen layout is stored, both registers hold their values until software re-arms the generator with a write to its re-arm strobe. Every parity bit is stored inverted, so a fully erased page reads back as an all-ones code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, both result outputs read 24'hFFFFFF and the generator is armed in short-block mode.
- R2: In short-block mode (mode latched 0), the code of the first 256 accepted bytes after arming appears on `code1` in the cycle after the 256th byte. The code of the next 256 bytes appears on `code2` in the cycle after the 512th byte. `code2` stays 24'hFFFFFF until then.
- R3: In long-block mode (mode latched 1), the code of the first 512 accepted bytes appears on `code1` in the cycle after the 512th byte, and `code2` stays 24'hFFFFFF.
- R4: Code layout. Bits [5:0] hold the inverted column parities: bit 2k is the parity of the data bits whose bit index has bit k clear, and bit 2k+1 is the parity of those whose bit index has bit k set. From bit 6 upward, pairs of inverted line parities follow: bit 6+2k is the parity of all bytes whose in-block index has bit k clear, and bit 7+2k is the parity of those whose index has bit k set. This uses 8 index bits in short mode and 9 in long mode. The unused bits [23:22] of a short-mode code read 1.
- R5: After the last code of the latched layout is stored, `code1` and `code2` stay unchanged whatever bytes follow, until the next re-arm.
- R6: A pulse on `rearm` sets both outputs to 24'hFFFFFF, latches `mode_512`, and restarts the byte count from the next accepted byte. A byte presented in the same cycle as `rearm` is not counted.
- R7: A byte is accepted only in a cycle where `dv` is 1. Cycles with `dv` at 0 leave the count and the codes unchanged.
- R8: When `byte_wide` is 0, bytes presented with `dv` at 1 are ignored and do not shift the block contents.
- R9: A block in which every byte is 8'hFF gives the code 24'hFFFFFF.
- R10: When a single data bit of a block is flipped, the XOR of the two codes has exactly one bit set in each parity pair (bits 2k and 2k+1), which locates the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm | input | 1 | Re-arm strobe (a write of any value to the reset register) |
| mode_512 | input | 1 | Layout select latched on re-arm: 0 two 256-byte codes, 1 one 512-byte code |
| byte_wide | input | 1 | 1 when the data interface is configured byte-wide |
| dv | input | 1 | Data-valid strobe for `din` |
| din | input | 8 | Stream byte |
| code1 | output | 24 | Result register one |
| code2 | output | 24 | Result register two |

## Verification
The hardest state to reach from the ports is the frozen state entered after exactly 512 counted bytes. The bench has to get there through gaps in `dv`, dropped bytes with `byte_wide` low, and a byte that coincides with a re-arm, because any one miscounted byte moves every later block boundary. Random streams with random idle gaps cover both layouts, and the bench compares each result against a bench-side parity model. Directed runs add an erased page, a single set bit, a stream that goes on past the freeze, and a pair of runs that differ in one bit, which exposes the syndrome pattern.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int CODE_W = 24;
    localparam int COL_W  = 6;

    // Selects data bits whose bit index has bit k equal to hi
    function automatic logic [7:0] col_mask(input int k, input int hi);
        logic [7:0] m;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            if (((j >> k) & 1) == hi) m[j] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_col_par.sv
module ecc_col_par
    import nand_ecc_pkg::*;
(
    input  logic [7:0]       data,
    output logic [COL_W-1:0] cp,
    output logic             bpar
);

    for (genvar k = 0; k < COL_W / 2; k++) begin : g_pair
        assign cp[2*k]   = ^(data & col_mask(k, 0));
        assign cp[2*k+1] = ^(data & col_mask(k, 1));
    end

    assign bpar = ^data;

endmodule

// File: rtl/ecc_line_acc.sv
module ecc_line_acc
    import nand_ecc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [COL_W-1:0]     cp_in,
    input  logic                 bpar,
    output logic [COL_W-1:0]     cp_nx,
    output logic [2*IDX_W-1:0]   lp_nx
);

    typedef struct packed {
        logic [COL_W-1:0]   cp;
        logic [2*IDX_W-1:0] lp;
    } acc_t;

    acc_t acc_q, acc_nx, acc_d;

    always_comb begin
        acc_nx = acc_q;
        if (en) begin
            acc_nx.cp = acc_q.cp ^ cp_in;
            for (int k = 0; k < IDX_W; k++) begin
                if (idx[k]) acc_nx.lp[2*k+1] = acc_q.lp[2*k+1] ^ bpar;
                else        acc_nx.lp[2*k]   = acc_q.lp[2*k]   ^ bpar;
            end
        end
        acc_d = clr ? '0 : acc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign cp_nx = acc_nx.cp;
    assign lp_nx = acc_nx.lp;

    // R6
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q.cp == '0) && (acc_q.lp == '0));

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int BLK_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm,
    input  logic              mode_512,
    input  logic              byte_wide,
    input  logic              dv,
    input  logic [7:0]        din,
    output logic [CODE_W-1:0] code1,
    output logic [CODE_W-1:0] code2
);

    localparam int IDX_W   = BLK_LOG2 + 1;
    localparam int SHORT_W = COL_W + 2 * BLK_LOG2;
    localparam int LONG_W  = COL_W + 2 * IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0]  cnt;
        logic              frozen;
        logic              mode;
        logic [CODE_W-1:0] c1;
        logic [CODE_W-1:0] c2;
    } st_t;

    st_t st_q, st_d;

    logic [COL_W-1:0]   cp_byte;
    logic               bpar;
    logic [COL_W-1:0]   cp_nx;
    logic [2*IDX_W-1:0] lp_nx;
    logic               accept;
    logic               last;
    logic [IDX_W-1:0]   idx;
    logic [CODE_W-1:0]  short_code;
    logic [CODE_W-1:0]  long_code;

    ecc_col_par u_col (
        .data (din),
        .cp   (cp_byte),
        .bpar (bpar)
    );

    ecc_line_acc #(.IDX_W(IDX_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rearm | (accept & last)),
        .en    (accept),
        .idx   (idx),
        .cp_in (cp_byte),
        .bpar  (bpar),
        .cp_nx (cp_nx),
        .lp_nx (lp_nx)
    );

    always_comb begin
        accept = dv && byte_wide && !st_q.frozen && !rearm;
        idx    = st_q.mode ? st_q.cnt : {1'b0, st_q.cnt[BLK_LOG2-1:0]};
        last   = st_q.mode ? (st_q.cnt == '1) : (st_q.cnt[BLK_LOG2-1:0] == '1);

        short_code = '1;
        short_code[SHORT_W-1:0] = ~{lp_nx[2*BLK_LOG2-1:0], cp_nx};
        long_code = '1;
        long_code[LONG_W-1:0] = ~{lp_nx, cp_nx};

        st_d = st_q;
        if (rearm) begin
            st_d.cnt    = '0;
            st_d.frozen = 1'b0;
            st_d.mode   = mode_512;
            st_d.c1     = '1;
            st_d.c2     = '1;
        end else if (accept) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (last) begin
                if (st_q.mode)                st_d.c1 = long_code;
                else if (st_q.cnt[IDX_W-1])   st_d.c2 = short_code;
                else                          st_d.c1 = short_code;
            end
            if (st_q.cnt == '1) st_d.frozen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.frozen <= 1'b0;
            st_q.mode   <= 1'b0;
            st_q.c1     <= '1;
            st_q.c2     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code1 = st_q.c1;
    assign code2 = st_q.c2;

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.frozen && !rearm) |=> ($stable(code1) && $stable(code2)));

    // R3
    long_code2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode |-> (code2 == '1));

    // R6
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> ((st_q.cnt == '0) && !st_q.frozen && (code1 == '1) && (code2 == '1)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm && !dv) |=> ($stable(st_q.cnt) && $stable(code1) && $stable(code2)));

    // R8
    narrow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm && !byte_wide) |=> ($stable(st_q.cnt) && $stable(code1) && $stable(code2)));

    // R4
    short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> (code1[CODE_W-1:SHORT_W] == '1));

endmodule

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rearm = 1'b0;
    logic        mode_512 = 1'b0;
    logic        byte_wide = 1'b1;
    logic        dv = 1'b0;
    logic [7:0]  din = '0;
    logic [23:0] code1, code2;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mem [0:511];

    always #10 clk = ~clk;

    nand_ecc_gen uut (
        .clk(clk), .rst_n(rst_n), .rearm(rearm), .mode_512(mode_512),
        .byte_wide(byte_wide), .dv(dv), .din(din), .code1(code1), .code2(code2)
    );

    function automatic logic [23:0] model(int base, int n, bit m512);
        logic [5:0]  cp;
        logic [17:0] lp;
        logic [7:0]  b;
        logic [23:0] r;
        int abits;
        cp = '0; lp = '0;
        abits = m512 ? 9 : 8;
        for (int i = 0; i < n; i++) begin
            b = mem[base + i];
            for (int j = 0; j < 8; j++) begin
                if (b[j]) begin
                    for (int k = 0; k < 3; k++) begin
                        if (((j >> k) & 1) == 1) cp[2*k+1] = ~cp[2*k+1];
                        else                     cp[2*k]   = ~cp[2*k];
                    end
                end
            end
            for (int k = 0; k < abits; k++) begin
                if (((i >> k) & 1) == 1) lp[2*k+1] = lp[2*k+1] ^ (^b);
                else                     lp[2*k]   = lp[2*k]   ^ (^b);
            end
        end
        r = '1;
        if (m512) r = {~lp, ~cp};
        else      r[21:0] = {~lp[15:0], ~cp};
        return r;
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b, int gap);
        din = b;
        dv = 1'b1;
        @(negedge clk);
        dv = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_rearm(bit m, bit with_byte);
        rearm = 1'b1;
        mode_512 = m;
        if (with_byte) begin
            dv = 1'b1;
            din = 8'h5A;
        end
        @(negedge clk);
        rearm = 1'b0;
        dv = 1'b0;
    endtask

    task automatic feed(int base, int n, bit gaps);
        for (int i = 0; i < n; i++) push(mem[base + i], gaps ? int'($urandom % 3) : 0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [23:0] a, b1, syn;
        int ok;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 code1", code1, 24'hFFFFFF);
        chk("R1 code2", code2, 24'hFFFFFF);

        // R2, R7 short-block mode straight out of reset, random gaps
        fill_random();
        feed(0, 256, 1);
        chk("R2 code1 block0", code1, model(0, 256, 0));
        chk("R2 code2 untouched", code2, 24'hFFFFFF);
        feed(256, 256, 1);
        chk("R2 code2 block1", code2, model(256, 256, 0));
        chk("R7 code1 after gaps", code1, model(0, 256, 0));

        // R5 freeze against further traffic
        a = code1; b1 = code2;
        for (int i = 0; i < 40; i++) push(8'($urandom), 0);
        chk("R5 code1 frozen", code1, a);
        chk("R5 code2 frozen", code2, b1);

        // R6 re-arm clears, R3 long-block mode
        do_rearm(1'b1, 1'b0);
        chk("R6 code1 cleared", code1, 24'hFFFFFF);
        chk("R6 code2 cleared", code2, 24'hFFFFFF);
        fill_random();
        feed(0, 511, 1);
        chk("R3 code1 before last byte", code1, 24'hFFFFFF);
        feed(511, 1, 0);
        chk("R3 code1 long", code1, model(0, 512, 1));
        chk("R3 code2 unused", code2, 24'hFFFFFF);

        // R9 erased page, short mode
        do_rearm(1'b0, 1'b0);
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        feed(0, 512, 0);
        chk("R9 erased code1", code1, 24'hFFFFFF);
        chk("R9 erased code2", code2, 24'hFFFFFF);

        // R4 single set bit at byte 0 bit 0
        do_rearm(1'b0, 1'b0);
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[0] = 8'h01;
        feed(0, 256, 0);
        chk("R4 single bit layout", code1, 24'hEAAAAA);

        // R6 byte coinciding with re-arm is not counted
        do_rearm(1'b0, 1'b1);
        fill_random();
        feed(0, 256, 1);
        chk("R6 coincident byte dropped", code1, model(0, 256, 0));

        // R8 narrow interface bytes ignored
        do_rearm(1'b0, 1'b0);
        fill_random();
        feed(0, 100, 0);
        byte_wide = 1'b0;
        for (int i = 0; i < 10; i++) push(8'($urandom), 0);
        byte_wide = 1'b1;
        feed(100, 156, 0);
        chk("R8 narrow ignored", code1, model(0, 256, 0));

        // R10 single bit flip syndrome, short and long modes
        for (int m = 0; m < 2; m++) begin
            do_rearm(m[0], 1'b0);
            fill_random();
            feed(0, 512, 0);
            a = code1;
            mem[m == 0 ? 37 : 300] ^= 8'h10;
            do_rearm(m[0], 1'b0);
            feed(0, 512, 0);
            syn = a ^ code1;
            ok = 1;
            for (int k = 0; k < (m == 0 ? 11 : 12); k++)
                if ((syn[2*k] ^ syn[2*k+1]) != 1'b1) ok = 0;
            if (m == 0 && syn[23:22] != 2'b00) ok = 0;
            chk("R10 syndrome pairs", 24'(ok), 24'd1);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule